// File: doc/BRIEF.md
# Daisy-Chain Bus Slave Controller

This block is the digital core of a slave node on a two-wire bus that carries both supply and signalling. The bus level reaches the block as two comparator outputs: one is high while the bus is below the low threshold, the other is high while the bus is above the high threshold. A word begins when the bus falls out of its idle level and then below the low threshold. It ends when the bus climbs back above the high threshold. Each bit begins with a low interval and ends with a high interval. The block times both intervals on its own clock, so it needs no knowledge of the master's bit rate. A bit whose high part lasts longer than its low part is a one.

A received word is accepted only when its length is valid and its 4-bit check code matches. The block then compares the address field with its own address or with the all-slaves address 0. It either answers a read or passes the command to the application through a one-cycle strobe. Any answer is returned during the next word the master sends, one bit per bit time, through a current-sink enable. At power-up the node has no address and its downstream bus switch is open. The first valid initialise command stores an address, closes the switch and queues a single echo of the programmed information. This lets the master number a chain of nodes one at a time.

Top module: `chainNodeSlave`

## Requirements
- R1: A word starts only after the bus has gone below the high threshold (busAboveHigh low) and then below the low threshold (busBelowLow high). It ends on the first clock in which busAboveHigh is high again. sinkOn is low outside the bits of a word.
- R2: Each bit starts when busBelowLow rises and ends when busBelowLow next rises or the word ends. The bit is 1 when the clocks counted with busBelowLow low outnumber those counted with it high, and 0 otherwise, whatever the bit period.
- R3: Bits arrive MSB first. A 12-bit word is address[3:0], command[3:0], check[3:0]. A 20-bit word is data[7:0], address[3:0], command[3:0], check[3:0]. Words of any other length are discarded.
- R4: The check code is polynomial x^4+x+1 with seed 4'b1010, shifted MSB first over all bits before the check field. A word that fails the check produces no strobe, no state change and no answer.
- R5: After reset the node address is 0, switchClosed is low, sinkOn is low and cmdStrobe is low.
- R6: While uninitialised, a valid word with command 4'hA and a nonzero address stores that address and sets switchClosed on the second clock edge after the word end. switchClosed then stays high.
- R7: The answer to that initialise word is sent once: {address, command} as 8 bits for a short word, or {address, command, data} as 16 bits for a long word, followed by its check code. Command 4'hA is ignored once initialised.
- R8: While uninitialised, every command other than a valid initialise is ignored: no strobe and an all-zero answer.
- R9: Once initialised, command 4'h1 to the node's own address is answered with sensorData[7:0] for a short word or sensorData[15:0] for a long word, sampled one clock after the word end.
- R10: Once initialised, any other command to the node's own address pulses cmdStrobe for one clock on the second edge after the word end. cmdCode carries the command and cmdData carries the data byte (0 for a short word). The answer echoes the word as in R7. Words addressed to another node produce neither strobe nor answer.
- R11: Once initialised, a valid non-initialise word to address 0 pulses cmdStrobe as in R10 and produces no answer.
- R12: An answer drives sinkOn during the next word only. Answer bit k, MSB first, with the check code after the data, is output from the clock after bit k starts until bit k+1 starts. Bits beyond the answer's length, and all bits of words that follow a word without an answer, leave sinkOn low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Node oscillator clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busBelowLow | input | 1 | High while the bus is below the low threshold |
| busAboveHigh | input | 1 | High while the bus is above the high threshold |
| sensorData | input | 16 | Application value returned by the read command |
| sinkOn | output | 1 | Enables the response current sink |
| switchClosed | output | 1 | Closes the downstream bus switch |
| cmdStrobe | output | 1 | One-clock pulse for an accepted application command |
| cmdCode | output | 4 | Command of the accepted word |
| cmdData | output | 8 | Data byte of the accepted word |

## Verification
Most internal faults show up within one word on sinkOn. A wrong bit decision, a lost edge, a wrong check code or a wrong address compare all change the answer bits sent during the next word. They can also make the node answer when it should stay silent, so the reference model compares sinkOn on every clock of every bit. A wrong initialisation state shows on switchClosed two clocks after the word end. It then shows again as a missing or repeated echo in the next word. Command routing faults show on cmdStrobe, cmdCode and cmdData in that same clock.

// File: rtl/chainNodePkg.sv
package chainNodePkg;
  localparam int SHORT_LEN = 12;
  localparam int LONG_LEN  = 20;
  localparam int RESP_W    = 20;
  localparam int BITCNT_W  = $clog2(LONG_LEN + 1);

  localparam logic [3:0] CMD_INIT = 4'hA;
  localparam logic [3:0] CMD_READ = 4'h1;
  localparam logic [3:0] CRC_SEED = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARMED, ST_LOW, ST_HIGH, ST_CHECK
  } frameState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              frameStart;
    logic              bitDone;
    logic              inFrame;
    logic              respLoad;
    logic [RESP_W-1:0] respWord;
  } ctlStrobe_t;

  // x^4+x+1, MSB first over the first len bits of a left-justified message
  function automatic logic [3:0] crcOf(input logic [15:0] msg, input int len);
    logic [3:0] c;
    logic fb;
    c = CRC_SEED;
    for (int i = 0; i < 16; i++) begin
      if (i < len) begin
        fb = c[3] ^ msg[15-i];
        c  = {c[2:0], 1'b0} ^ (fb ? 4'b0011 : 4'b0000);
      end
    end
    return c;
  endfunction
endpackage

// File: rtl/chainNodeDatapath.sv
module chainNodeDatapath
  import chainNodePkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busBelowLow,
  input  ctlStrobe_t          ctl,
  output logic [LONG_LEN-1:0] rxWord,
  output logic                rxShort,
  output logic                rxLong,
  output logic                crcOk,
  output logic                sinkOn
);
  localparam logic [CNT_W-1:0]    CNT_MAX   = '1;
  localparam logic [CNT_W-1:0]    CNT_ONE   = CNT_W'(1);
  localparam logic [BITCNT_W-1:0] BITS_MAX  = '1;
  localparam logic [BITCNT_W-1:0] SHORT_CNT = BITCNT_W'(SHORT_LEN);
  localparam logic [BITCNT_W-1:0] LONG_CNT  = BITCNT_W'(LONG_LEN);

  logic [CNT_W-1:0]    lowCnt, highCnt;
  logic [BITCNT_W-1:0] rxCount;
  logic [RESP_W-1:0]   respShift;
  logic                bitValue;

  // ratio decision: more high time than low time is a one
  assign bitValue = (highCnt > lowCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt  <= '0;
      highCnt <= '0;
    end else if (ctl.frameStart || ctl.bitDone) begin
      lowCnt  <= CNT_ONE;
      highCnt <= '0;
    end else if (ctl.inFrame) begin
      if (busBelowLow) begin
        if (lowCnt != CNT_MAX) lowCnt <= lowCnt + CNT_ONE;
      end else if (highCnt != CNT_MAX) begin
        highCnt <= highCnt + CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxWord  <= '0;
      rxCount <= '0;
    end else if (ctl.frameStart) begin
      rxWord  <= '0;
      rxCount <= '0;
    end else if (ctl.bitDone) begin
      rxWord <= {rxWord[LONG_LEN-2:0], bitValue};
      if (rxCount != BITS_MAX) rxCount <= rxCount + BITCNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respShift <= '0;
    end else if (ctl.respLoad) begin
      respShift <= ctl.respWord;
    end else if (ctl.bitDone) begin
      respShift <= {respShift[RESP_W-2:0], 1'b0};
    end
  end

  assign rxShort = (rxCount == SHORT_CNT);
  assign rxLong  = (rxCount == LONG_CNT);

  always_comb begin
    if (rxLong) crcOk = (crcOf(rxWord[19:4], 16) == rxWord[3:0]);
    else        crcOk = (crcOf({rxWord[11:4], 8'h00}, 8) == rxWord[3:0]);
  end

  assign sinkOn = ctl.inFrame & respShift[RESP_W-1];

  // R2: a long low phase never wraps into a short one
  a_r2_low_count_saturates : assert property (@(posedge clk) disable iff (!rstN)
    (lowCnt == CNT_MAX && !ctl.frameStart && !ctl.bitDone) |=> (lowCnt == CNT_MAX));

  // R12: answer bits move one place per completed bit
  a_r12_resp_advances : assert property (@(posedge clk) disable iff (!rstN)
    (ctl.bitDone && !ctl.respLoad && respShift[RESP_W-2]) |=> respShift[RESP_W-1]);
endmodule

// File: rtl/chainNodeControl.sv
module chainNodeControl
  import chainNodePkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                busBelowLow,
  input  logic                busAboveHigh,
  input  logic [15:0]         sensorData,
  input  logic [LONG_LEN-1:0] rxWord,
  input  logic                rxShort,
  input  logic                rxLong,
  input  logic                crcOk,
  output ctlStrobe_t          ctl,
  output logic                switchClosed,
  output logic                cmdStrobe,
  output logic [3:0]          cmdCode,
  output logic [7:0]          cmdData
);
  frameState_t state, stateNext;
  logic [3:0]  nodeAddr;
  logic        initDone;

  logic [3:0]  fAddr, fCmd;
  logic [7:0]  fData;
  logic        frameOk, acceptInit, forMe, isBcast, hasResp, wantStrobe;
  logic [15:0] longResp;
  logic [7:0]  shortResp;
  logic [RESP_W-1:0] respWord;

  // word framing
  always_comb begin
    stateNext      = state;
    ctl.frameStart = 1'b0;
    ctl.bitDone    = 1'b0;
    unique case (state)
      ST_IDLE:  if (!busAboveHigh) stateNext = ST_ARMED;
      ST_ARMED: begin
        if (busAboveHigh) stateNext = ST_IDLE;
        else if (busBelowLow) begin
          stateNext      = ST_LOW;
          ctl.frameStart = 1'b1;
        end
      end
      ST_LOW: begin
        if (busAboveHigh) begin
          stateNext   = ST_CHECK;
          ctl.bitDone = 1'b1;
        end else if (!busBelowLow) stateNext = ST_HIGH;
      end
      ST_HIGH: begin
        if (busAboveHigh) begin
          stateNext   = ST_CHECK;
          ctl.bitDone = 1'b1;
        end else if (busBelowLow) begin
          stateNext   = ST_LOW;
          ctl.bitDone = 1'b1;
        end
      end
      ST_CHECK: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  // field decode and answer selection
  assign fAddr   = rxWord[11:8];
  assign fCmd    = rxWord[7:4];
  assign fData   = rxLong ? rxWord[19:12] : 8'h00;
  assign frameOk = (rxShort | rxLong) & crcOk;

  assign acceptInit = frameOk & !initDone & (fCmd == CMD_INIT) & (fAddr != 4'h0);
  assign forMe      = frameOk & initDone & (fCmd != CMD_INIT) & (fAddr == nodeAddr);
  assign isBcast    = frameOk & initDone & (fCmd != CMD_INIT) & (fAddr == 4'h0);
  assign hasResp    = acceptInit | forMe;
  assign wantStrobe = (forMe & (fCmd != CMD_READ)) | isBcast;

  always_comb begin
    if (forMe && fCmd == CMD_READ) begin
      longResp  = sensorData;
      shortResp = sensorData[7:0];
    end else begin
      longResp  = {fAddr, fCmd, fData};
      shortResp = {fAddr, fCmd};
    end
    if (!hasResp)    respWord = '0;
    else if (rxLong) respWord = {longResp, crcOf(longResp, 16)};
    else             respWord = {shortResp, crcOf({shortResp, 8'h00}, 8), 8'h00};
  end

  assign ctl.inFrame  = (state == ST_LOW) || (state == ST_HIGH);
  assign ctl.respLoad = (state == ST_CHECK);
  assign ctl.respWord = respWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      nodeAddr  <= 4'h0;
      initDone  <= 1'b0;
      cmdStrobe <= 1'b0;
      cmdCode   <= 4'h0;
      cmdData   <= 8'h00;
    end else begin
      state     <= stateNext;
      cmdStrobe <= 1'b0;
      if (state == ST_CHECK) begin
        if (acceptInit) begin
          nodeAddr <= fAddr;
          initDone <= 1'b1;
        end
        if (wantStrobe) begin
          cmdStrobe <= 1'b1;
          cmdCode   <= fCmd;
          cmdData   <= fData;
        end
      end
    end
  end

  assign switchClosed = initDone;

  // R6: once closed the switch never reopens
  a_r6_switch_latches : assert property (@(posedge clk) disable iff (!rstN)
    switchClosed |=> switchClosed);
  // R7: an initialised node always holds a unicast address
  a_r7_addr_nonzero : assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> (nodeAddr != 4'h0));
  // R8: no application command before initialisation
  a_r8_no_strobe_uninit : assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |-> $past(initDone));
  // R1: a word opens only from a bus below both thresholds
  a_r1_frame_entry : assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.inFrame) |-> ($past(busBelowLow) && !$past(busAboveHigh)));
endmodule

// File: rtl/chainNodeSlave.sv
module chainNodeSlave
  import chainNodePkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busBelowLow,
  input  logic        busAboveHigh,
  input  logic [15:0] sensorData,
  output logic        sinkOn,
  output logic        switchClosed,
  output logic        cmdStrobe,
  output logic [3:0]  cmdCode,
  output logic [7:0]  cmdData
);
  ctlStrobe_t          ctl;
  logic [LONG_LEN-1:0] rxWord;
  logic                rxShort, rxLong, crcOk;

  chainNodeControl u_control (
    .clk(clk), .rstN(rstN), .busBelowLow(busBelowLow), .busAboveHigh(busAboveHigh),
    .sensorData(sensorData), .rxWord(rxWord), .rxShort(rxShort), .rxLong(rxLong),
    .crcOk(crcOk), .ctl(ctl), .switchClosed(switchClosed), .cmdStrobe(cmdStrobe),
    .cmdCode(cmdCode), .cmdData(cmdData)
  );

  chainNodeDatapath #(.CNT_W(CNT_W)) u_datapath (
    .clk(clk), .rstN(rstN), .busBelowLow(busBelowLow), .ctl(ctl),
    .rxWord(rxWord), .rxShort(rxShort), .rxLong(rxLong), .crcOk(crcOk), .sinkOn(sinkOn)
  );
endmodule

// File: tb/chainNodeSlave_bench.sv
module chainNodeSlave_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic below = 1'b0;
  logic above = 1'b1;
  logic [15:0] sensor = 16'h0000;
  logic sinkOn, switchClosed, cmdStrobe;
  logic [3:0] cmdCode;
  logic [7:0] cmdData;

  int checks = 0;
  int fails = 0;
  string tagNow = "R5";

  // reference model state
  bit frameQ[$];
  bit expQ[$];
  bit nextQ[$];
  int mAddr = 0;
  bit mInit = 0;
  bit expSink = 0, expStrobe = 0;
  int expCode = 0, expData = 0;

  always #4 clk = ~clk;

  chainNodeSlave u_chainNodeSlave (
    .clk(clk), .rstN(rstN), .busBelowLow(below), .busAboveHigh(above),
    .sensorData(sensor), .sinkOn(sinkOn), .switchClosed(switchClosed),
    .cmdStrobe(cmdStrobe), .cmdCode(cmdCode), .cmdData(cmdData)
  );

  task automatic chk(string name, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h", tagNow, name, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk("R12 sinkOn", int'(sinkOn), int'(expSink));
    chk("R6 switchClosed", int'(switchClosed), int'(mInit));
    chk("R10 cmdStrobe", int'(cmdStrobe), int'(expStrobe));
    if (expStrobe) begin
      chk("R10 cmdCode", int'(cmdCode), expCode);
      chk("R10 cmdData", int'(cmdData), expData);
    end
  endtask

  function automatic int benchCrc(bit q[$], int n);
    int r = 10;
    for (int i = 0; i < n; i++) begin
      int top = (r >> 3) & 1;
      r = (r << 1) & 15;
      if ((top ^ int'(q[i])) != 0) r = r ^ 3;
    end
    return r;
  endfunction

  task automatic pushBits(ref bit q[$], input int v, input int w);
    for (int i = w - 1; i >= 0; i--) q.push_back(bit'((v >> i) & 1));
  endtask

  function automatic int fieldOf(int start, int w);
    int v = 0;
    for (int i = 0; i < w; i++) v = (v << 1) | int'(frameQ[start + i]);
    return v;
  endfunction

  task automatic buildFrame(bit isLong, int data, int addr, int cmd, bit badCrc);
    int c;
    frameQ.delete();
    if (isLong) pushBits(frameQ, data, 8);
    pushBits(frameQ, addr, 4);
    pushBits(frameQ, cmd, 4);
    c = benchCrc(frameQ, frameQ.size());
    if (badCrc) c = c ^ 1;
    pushBits(frameQ, c, 4);
  endtask

  task automatic queueResp(int v, int w);
    bit tmp[$];
    pushBits(tmp, v, w);
    nextQ = tmp;
    pushBits(nextQ, benchCrc(tmp, w), 4);
  endtask

  // expected effect of the word held in frameQ
  task automatic modelFrame();
    int n = frameQ.size();
    int base, addr, cmd, data, w;
    nextQ.delete();
    if (n != 12 && n != 20) return;
    if (benchCrc(frameQ, n - 4) != fieldOf(n - 4, 4)) return;
    base = n - 12;
    addr = fieldOf(base, 4);
    cmd  = fieldOf(base + 4, 4);
    data = (n == 20) ? fieldOf(0, 8) : 0;
    w    = (n == 20) ? 16 : 8;
    if (!mInit) begin
      if (cmd == 10 && addr != 0) begin
        mInit = 1;
        mAddr = addr;
        queueResp((n == 20) ? ((addr << 12) | (cmd << 8) | data) : ((addr << 4) | cmd), w);
      end
    end else if (cmd != 10) begin
      if (addr == mAddr) begin
        if (cmd == 1) queueResp((n == 20) ? int'(sensor) : int'(sensor[7:0]), w);
        else begin
          expStrobe = 1; expCode = cmd; expData = data;
          queueResp((n == 20) ? ((addr << 12) | (cmd << 8) | data) : ((addr << 4) | cmd), w);
        end
      end else if (addr == 0) begin
        expStrobe = 1; expCode = cmd; expData = data;
      end
    end
  endtask

  // drive frameQ with a third-of-bit unit of u clocks
  task automatic sendFrame(int u);
    above = 0; below = 0; expSink = 0;
    repeat (3) tick();
    for (int i = 0; i < frameQ.size(); i++) begin
      expSink = (i < expQ.size()) ? expQ[i] : 1'b0;
      below = 1;
      repeat (frameQ[i] ? u : 2 * u) tick();
      below = 0;
      repeat (frameQ[i] ? 2 * u : u) tick();
    end
    above = 1; below = 0; expSink = 0;
    tick();
    modelFrame();
    tick();
    expStrobe = 0;
    repeat (3) tick();
    expQ = nextQ;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tagNow = "R5 reset";
    tick();
    rstN = 1;
    repeat (2) tick();

    tagNow = "R8 R1 read before init";
    buildFrame(0, 0, 3, 1, 0); sendFrame(3);
    tagNow = "R6 R7 init short";
    buildFrame(0, 0, 3, 10, 0); sendFrame(3);
    tagNow = "R7 second init ignored";
    buildFrame(0, 0, 5, 10, 0); sendFrame(3);
    sensor = 16'h12C5;
    tagNow = "R9 short read";
    buildFrame(0, 0, 3, 1, 0); sendFrame(3);
    sensor = 16'hBEEF;
    tagNow = "R9 long read";
    buildFrame(1, 8'h33, 3, 1, 0); sendFrame(3);
    tagNow = "R10 long command";
    buildFrame(1, 8'h5A, 3, 6, 0); sendFrame(3);
    tagNow = "R10 other address";
    buildFrame(0, 0, 4, 6, 0); sendFrame(3);
    tagNow = "R11 broadcast";
    buildFrame(0, 0, 0, 9, 0); sendFrame(3);
    tagNow = "R4 bad check";
    buildFrame(1, 8'h11, 3, 1, 1); sendFrame(3);
    tagNow = "R3 bad length";
    frameQ.delete(); pushBits(frameQ, 10'h3A5, 10); sendFrame(3);
    sensor = 16'h00A9;
    tagNow = "R2 slower bits";
    buildFrame(0, 0, 3, 1, 0); sendFrame(5);
    tagNow = "R12 flush";
    buildFrame(1, 8'hC3, 3, 7, 0); sendFrame(2);
    tagNow = "R12 final";
    buildFrame(0, 0, 7, 6, 0); sendFrame(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule